// File: doc/BRIEF.md
# Interrupt-Capable GPIO Port

This block is one general-purpose I/O channel of up to sixteen pins, reached through a small word-addressed register port. Software programs the value each output pin drives and which pins drive at all. It reads back the pin levels after a two-stage synchronizer. Every pin can raise an interrupt on a rising edge, a falling edge, either edge, a high level or a low level. The chosen condition is latched into a per-pin status bit, which software clears by writing ones.

A per-pin enable controls whether a condition may set status at all. A separate per-pin mask controls whether a latched status bit reaches the single interrupt request line. The mask is set and cleared through two write-one registers, so no read-modify-write is needed. A display word shows the status with masked pins removed. The number of implemented pins is a parameter from 6 to 16. Bits above that count are not stored and read as zero.

The register port is synchronous. A write takes effect at the clock edge where the write enable is high. Read data is registered and returns the addressed word one edge after the address is presented.

Top module: `gpio_irq_port`

## Requirements
- R1: After a synchronous active-low reset every register reads zero, every pin is an input (pin_oe all zero), all interrupts are disabled and unmasked, and irq is low.
- R2: Word 6 (output data) and word 8 (direction) are read/write. pin_out follows word 6 and pin_oe follows word 8, where a 1 means output. Bits at or above PINS are dropped and read as zero.
- R3: Word 7 returns pin_in after two synchronizing flops. A pin change presented before edge k is first visible in read data captured at edge k+2.
- R4: Each pin has a 3-bit trigger code: 0 falling edge, 1 rising edge, 2 low level, 3 high level, 4 either edge, 5 to 7 never trigger. Word 9 holds pins 0-7 and word 10 holds pins 8-15. A pin's code sits at bit 4*(pin mod 8), and the top bit of every nibble reads zero. An edge compares the synchronized value with its value one cycle earlier.
- R5: A status bit (word 1) sets only when the trigger condition is true and the pin's enable bit (word 0) was 1 before that edge.
- R6: Writing 1s to word 3 clears those status bits and writing 0s has no effect. If a pin's condition is true in the same cycle as its clear, its status stays set, so an active level re-sets immediately.
- R7: Writing 1s to word 4 masks those pins and writing 1s to word 5 unmasks them. Word 4 reads back the current mask, and word 5 reads zero.
- R8: Word 2 reads status AND NOT mask, and irq is high exactly when that word is non-zero.
- R9: Writes to word 1 are ignored, and status bits at or above PINS never set.
- R10: Read data is registered. The word at bus_addr before edge k appears after edge k and shows state from before any write at that same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Word index of the register accessed |
| bus_we | input | 1 | Write strobe for the addressed word |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| pin_in | input | PINS | Asynchronous pin levels |
| pin_out | output | PINS | Output data toward the pads |
| pin_oe | output | PINS | Output enable toward the pads (1 = drive) |
| irq | output | 1 | Combined interrupt request |

## Verification
The assertions assume at most one register access per cycle, so a mask-set write and a mask-clear write can never fall on the same edge. They also assume bus_addr is a defined value whenever reset is released. pin_in may change at any time, because it is synchronized inside the block. The stimulus respects these assumptions by driving all inputs only on the falling clock edge. It issues one access per cycle and toggles pins only while the bus is idle or performing single writes.

// File: rtl/gpio_irq_pkg.sv
// Shared constants for the interrupt-capable GPIO port.
// Assumes a 32-bit register word and at most 16 pins per channel.
package gpio_irq_pkg;
    localparam int MAX_PINS     = 16;
    localparam int TRIG_W       = 3;   // width of one trigger code
    localparam int NIBBLE_W     = 4;   // spacing of codes in a mode word
    localparam int PINS_PER_MODE = 8;  // pins per mode word

    typedef enum logic [TRIG_W-1:0] {
        TRIG_FALL = 3'd0,
        TRIG_RISE = 3'd1,
        TRIG_LOW  = 3'd2,
        TRIG_HIGH = 3'd3,
        TRIG_ANY  = 3'd4
    } trig_e;

    // Word indices of the register map
    localparam logic [3:0] IDX_EN    = 4'd0;
    localparam logic [3:0] IDX_STAT  = 4'd1;
    localparam logic [3:0] IDX_DISP  = 4'd2;
    localparam logic [3:0] IDX_CLR   = 4'd3;
    localparam logic [3:0] IDX_MSET  = 4'd4;
    localparam logic [3:0] IDX_MCLR  = 4'd5;
    localparam logic [3:0] IDX_DOUT  = 4'd6;
    localparam logic [3:0] IDX_DIN   = 4'd7;
    localparam logic [3:0] IDX_DIR   = 4'd8;
    localparam logic [3:0] IDX_MODE0 = 4'd9;
    localparam logic [3:0] IDX_MODE1 = 4'd10;
endpackage

// File: rtl/gpio_in_sync.sv
// Two-flop synchronizer plus a history flop for edge detection.
// Assumes inputs are asynchronous; reset clears all stages to zero.
module gpio_in_sync #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q_now,
    output logic [W-1:0] q_prev
);
    logic [W-1:0] meta_q;

    // Shift raw pins through two stages and keep one cycle of history
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            q_now  <= '0;
            q_prev <= '0;
        end else begin
            meta_q <= d;
            q_now  <= meta_q;
            q_prev <= q_now;
        end
    end
endmodule

// File: rtl/gpio_trig_detect.sv
// Per-pin trigger evaluation from a 3-bit code and synchronized levels.
// Purely combinational; codes outside the defined set never trigger.
module gpio_trig_detect
    import gpio_irq_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0]        cur,
    input  logic [W-1:0]        prev,
    input  logic [W*TRIG_W-1:0] modes,
    output logic [W-1:0]        hit
);
    for (genvar gi = 0; gi < W; gi++) begin : g_pin
        logic [TRIG_W-1:0] code;
        assign code = modes[gi*TRIG_W +: TRIG_W];

        // Decode this pin's condition
        always_comb begin
            case (code)
                TRIG_FALL: hit[gi] = prev[gi] & ~cur[gi];
                TRIG_RISE: hit[gi] = ~prev[gi] & cur[gi];
                TRIG_LOW:  hit[gi] = ~cur[gi];
                TRIG_HIGH: hit[gi] = cur[gi];
                TRIG_ANY:  hit[gi] = prev[gi] ^ cur[gi];
                default:   hit[gi] = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/gpio_irq_status.sv
// Latched interrupt status, mask state and the combined request.
// Assumes mask-set and mask-clear strobes arrive one-hot per cycle.
module gpio_irq_status #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] hit,
    input  logic [W-1:0] en,
    input  logic [W-1:0] clr,
    input  logic [W-1:0] mset,
    input  logic [W-1:0] mclr,
    output logic [W-1:0] stat,
    output logic [W-1:0] mask,
    output logic [W-1:0] disp,
    output logic         irq
);
    // Status: clear by write-one, set wins when enabled condition present
    always_ff @(posedge clk) begin
        if (!rst_n) stat <= '0;
        else        stat <= (stat & ~clr) | (hit & en);
    end

    // Mask: independent set and clear strobes
    always_ff @(posedge clk) begin
        if (!rst_n) mask <= '0;
        else        mask <= (mask | mset) & ~mclr;
    end

    // Unmasked view and combined request
    always_comb begin
        disp = stat & ~mask;
        irq  = |disp;
    end
endmodule

// File: rtl/gpio_irq_port.sv
// Top of the interrupt-capable GPIO channel: register file, read mux,
// synchronizer, trigger decode and status. Assumes 6 <= PINS <= 16.
module gpio_irq_port
    import gpio_irq_pkg::*;
#(
    parameter int PINS   = 16,
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [PINS-1:0]   pin_in,
    output logic [PINS-1:0]   pin_out,
    output logic [PINS-1:0]   pin_oe,
    output logic              irq
);
    localparam int MODE_W = PINS * TRIG_W;

    logic [PINS-1:0]   en_q, dout_q, dir_q;
    logic [MODE_W-1:0] mode_q;
    logic [PINS-1:0]   sync_cur, sync_prev, hit;
    logic [PINS-1:0]   stat_q, mask_q, disp;
    logic [PINS-1:0]   clr_bits, mset_bits, mclr_bits;
    logic [DATA_W-1:0] mode_lo_word, mode_hi_word, rd_mux;
    logic              wr_en, wr_dout, wr_dir, wr_mode0, wr_mode1;

    // Write strobes per word
    always_comb begin
        wr_en    = bus_we && (bus_addr == ADDR_W'(IDX_EN));
        wr_dout  = bus_we && (bus_addr == ADDR_W'(IDX_DOUT));
        wr_dir   = bus_we && (bus_addr == ADDR_W'(IDX_DIR));
        wr_mode0 = bus_we && (bus_addr == ADDR_W'(IDX_MODE0));
        wr_mode1 = bus_we && (bus_addr == ADDR_W'(IDX_MODE1));
        clr_bits  = (bus_we && bus_addr == ADDR_W'(IDX_CLR))  ? bus_wdata[PINS-1:0] : '0;
        mset_bits = (bus_we && bus_addr == ADDR_W'(IDX_MSET)) ? bus_wdata[PINS-1:0] : '0;
        mclr_bits = (bus_we && bus_addr == ADDR_W'(IDX_MCLR)) ? bus_wdata[PINS-1:0] : '0;
    end

    // Plain read/write control words
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= '0;
            dout_q <= '0;
            dir_q  <= '0;
        end else begin
            if (wr_en)   en_q   <= bus_wdata[PINS-1:0];
            if (wr_dout) dout_q <= bus_wdata[PINS-1:0];
            if (wr_dir)  dir_q  <= bus_wdata[PINS-1:0];
        end
    end

    // Trigger codes unpacked from the two nibble-spaced mode words
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
        end else begin
            for (int i = 0; i < PINS && i < PINS_PER_MODE; i++)
                if (wr_mode0)
                    mode_q[i*TRIG_W +: TRIG_W] <= bus_wdata[i*NIBBLE_W +: TRIG_W];
            for (int i = PINS_PER_MODE; i < PINS; i++)
                if (wr_mode1)
                    mode_q[i*TRIG_W +: TRIG_W] <=
                        bus_wdata[(i-PINS_PER_MODE)*NIBBLE_W +: TRIG_W];
        end
    end

    // Repack trigger codes for read-back, spare nibble bit zero
    always_comb begin
        mode_lo_word = '0;
        mode_hi_word = '0;
        for (int i = 0; i < PINS && i < PINS_PER_MODE; i++)
            mode_lo_word[i*NIBBLE_W +: TRIG_W] = mode_q[i*TRIG_W +: TRIG_W];
        for (int i = PINS_PER_MODE; i < PINS; i++)
            mode_hi_word[(i-PINS_PER_MODE)*NIBBLE_W +: TRIG_W] = mode_q[i*TRIG_W +: TRIG_W];
    end

    gpio_in_sync #(.W(PINS)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .d      (pin_in),
        .q_now  (sync_cur),
        .q_prev (sync_prev)
    );

    gpio_trig_detect #(.W(PINS)) u_trig (
        .cur   (sync_cur),
        .prev  (sync_prev),
        .modes (mode_q),
        .hit   (hit)
    );

    gpio_irq_status #(.W(PINS)) u_stat (
        .clk   (clk),
        .rst_n (rst_n),
        .hit   (hit),
        .en    (en_q),
        .clr   (clr_bits),
        .mset  (mset_bits),
        .mclr  (mclr_bits),
        .stat  (stat_q),
        .mask  (mask_q),
        .disp  (disp),
        .irq   (irq)
    );

    // Select the addressed word
    always_comb begin
        case (bus_addr)
            ADDR_W'(IDX_EN):    rd_mux = DATA_W'(en_q);
            ADDR_W'(IDX_STAT):  rd_mux = DATA_W'(stat_q);
            ADDR_W'(IDX_DISP):  rd_mux = DATA_W'(disp);
            ADDR_W'(IDX_MSET):  rd_mux = DATA_W'(mask_q);
            ADDR_W'(IDX_DOUT):  rd_mux = DATA_W'(dout_q);
            ADDR_W'(IDX_DIN):   rd_mux = DATA_W'(sync_cur);
            ADDR_W'(IDX_DIR):   rd_mux = DATA_W'(dir_q);
            ADDR_W'(IDX_MODE0): rd_mux = mode_lo_word;
            ADDR_W'(IDX_MODE1): rd_mux = mode_hi_word;
            default:            rd_mux = '0;
        endcase
    end

    // Register read data
    always_ff @(posedge clk) begin
        if (!rst_n) bus_rdata <= '0;
        else        bus_rdata <= rd_mux;
    end

    assign pin_out = dout_q;
    assign pin_oe  = dir_q;
endmodule

// File: rtl/gpio_irq_port_chk.sv
// Property checker for gpio_irq_port, attached by bind.
// Assumes one register access per cycle.
module gpio_irq_port_chk #(
    parameter int PINS   = 16,
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              we,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic [DATA_W-1:0] rdata,
    input logic [PINS-1:0]   stat,
    input logic [PINS-1:0]   mask,
    input logic [PINS-1:0]   en,
    input logic [PINS-1:0]   hit,
    input logic              irq
);
    // R5
    stat_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((stat & ~$past(stat) & ~$past(en)) == '0));

    // R6
    clr_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == ADDR_W'(3)) |=>
        ((stat & $past(wdata[PINS-1:0]) & ~$past(hit & en)) == '0));

    // R7
    mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == ADDR_W'(4)) |=>
        ((mask & $past(wdata[PINS-1:0])) == $past(wdata[PINS-1:0])));

    // R7
    mask_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == ADDR_W'(5)) |=> ((mask & $past(wdata[PINS-1:0])) == '0));

    // R8
    irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((stat & ~mask) != '0));

    // R9
    stat_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!we && addr == ADDR_W'(1)) |=> (rdata[DATA_W-1:PINS] == '0));
endmodule

bind gpio_irq_port gpio_irq_port_chk #(
    .PINS(PINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (bus_we),
    .addr  (bus_addr),
    .wdata (bus_wdata),
    .rdata (bus_rdata),
    .stat  (stat_q),
    .mask  (mask_q),
    .en    (en_q),
    .hit   (hit),
    .irq   (irq)
);

// File: tb/gpio_irq_port_test.sv
// Bench: behavioural reference model compared every clock, plus directed checks.
module gpio_irq_port_test;
    localparam int PINS = 12;
    localparam logic [15:0] PM = 16'((1 << PINS) - 1);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [PINS-1:0] pin_in = '0;
    logic [PINS-1:0] pin_out, pin_oe;
    logic        irq;

    int errors = 0;
    int checks = 0;
    string cur_req = "R1";
    bit live = 1'b0;

    always #10 clk = ~clk;

    gpio_irq_port #(.PINS(PINS)) uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    // Reference model state
    logic [15:0] m_en, m_st, m_mk, m_do, m_dir;
    logic [2:0]  m_mode [16];
    logic [31:0] m_rd;
    logic [15:0] hist [$];

    function automatic logic [31:0] mdl_read(logic [3:0] a);
        logic [31:0] r = '0;
        case (a)
            4'd0: r = {16'h0, m_en};
            4'd1: r = {16'h0, m_st};
            4'd2: r = {16'h0, m_st & ~m_mk};
            4'd4: r = {16'h0, m_mk};
            4'd6: r = {16'h0, m_do};
            4'd7: r = {16'h0, hist[1]};
            4'd8: r = {16'h0, m_dir};
            4'd9:  for (int i = 0; i < 8; i++) if (i < PINS) r[i*4 +: 3] = m_mode[i];
            4'd10: for (int i = 8; i < 16; i++) if (i < PINS) r[(i-8)*4 +: 3] = m_mode[i];
            default: r = '0;
        endcase
        return r;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_en = '0; m_st = '0; m_mk = '0; m_do = '0; m_dir = '0; m_rd = '0;
            for (int i = 0; i < 16; i++) m_mode[i] = '0;
            hist = {16'h0, 16'h0, 16'h0};
        end else begin
            logic [15:0] cur, prv, hitv, wd;
            cur = hist[1];
            prv = hist[0];
            m_rd = mdl_read(bus_addr);
            hitv = '0;
            for (int i = 0; i < PINS; i++) begin
                case (m_mode[i])
                    3'd0: hitv[i] = prv[i] & ~cur[i];
                    3'd1: hitv[i] = ~prv[i] & cur[i];
                    3'd2: hitv[i] = ~cur[i];
                    3'd3: hitv[i] = cur[i];
                    3'd4: hitv[i] = prv[i] ^ cur[i];
                    default: hitv[i] = 1'b0;
                endcase
            end
            wd = bus_wdata[15:0] & PM;
            if (bus_we && bus_addr == 4'd3) m_st = (m_st & ~wd) | (hitv & m_en);
            else                            m_st = m_st | (hitv & m_en);
            if (bus_we) begin
                case (bus_addr)
                    4'd0: m_en = wd;
                    4'd4: m_mk = m_mk | wd;
                    4'd5: m_mk = m_mk & ~wd;
                    4'd6: m_do = wd;
                    4'd8: m_dir = wd;
                    4'd9:  for (int i = 0; i < 8; i++) if (i < PINS) m_mode[i] = bus_wdata[i*4 +: 3];
                    4'd10: for (int i = 8; i < 16; i++) if (i < PINS) m_mode[i] = bus_wdata[(i-8)*4 +: 3];
                    default: ;
                endcase
            end
            hist.push_back(16'(pin_in));
            void'(hist.pop_front());
        end
    end

    task automatic check(string req, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Compare the design with the model on every clock
    always @(negedge clk) begin
        if (rst_n && live) begin
            check({cur_req, " rdata"}, bus_rdata, m_rd);
            check({cur_req, " irq"}, {31'h0, irq}, {31'h0, |(m_st & ~m_mk)});
            check("R2 pin_out", 32'(pin_out), 32'(m_do));
            check("R2 pin_oe", 32'(pin_oe), 32'(m_dir));
        end
    end

    task automatic wr(logic [3:0] a, logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(logic [3:0] a, output logic [31:0] v);
        bus_addr = a; bus_we = 1'b0;
        @(negedge clk);
        v = bus_rdata;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        live = 1'b1;

        // R1: reset state
        cur_req = "R1";
        for (int a = 0; a < 12; a++) begin
            rd(4'(a), v);
            check("R1 reset word", v, 32'h0);
        end
        check("R1 pin_oe", 32'(pin_oe), 32'h0);
        check("R1 irq", {31'h0, irq}, 32'h0);

        // R2: output data and direction, upper bits dropped
        cur_req = "R2";
        wr(4'd6, 32'hFFFF_FFFF);
        wr(4'd8, 32'hFFFF_FA5F);
        rd(4'd8, v); check("R2 dir readback", v, 32'h0000_0A5F);
        rd(4'd6, v); check("R2 dout readback", v, 32'h0000_0FFF);
        check("R2 pin_oe", 32'(pin_oe), 32'h0A5F);
        wr(4'd6, 32'h0000_0123);
        check("R2 pin_out", 32'(pin_out), 32'h0123);

        // R3: synchronized input read
        cur_req = "R3";
        pin_in = 12'h5A3; idle(4);
        rd(4'd7, v); check("R3 din", v, 32'h5A3);
        pin_in = 12'h0F0;
        rd(4'd7, v); check("R3 sync delay", v, 32'h5A3);
        idle(3);
        rd(4'd7, v); check("R3 din new", v, 32'h0F0);

        // R4: mode field packing
        cur_req = "R4";
        wr(4'd9, 32'hFFFF_FFFF);
        rd(4'd9, v); check("R4 mode0 pack", v, 32'h7777_7777);
        wr(4'd10, 32'hFFFF_FFFF);
        rd(4'd10, v); check("R4 mode1 pack", v, 32'h0000_7777);
        wr(4'd9, 32'h0154_3210);
        wr(4'd10, 32'h0000_0041);
        pin_in = 12'h000; idle(5);

        // R5: disabled pins do not latch
        cur_req = "R5";
        wr(4'd3, 32'h0000_0FFF);
        rd(4'd1, v); check("R5 no enable", v, 32'h0);
        wr(4'd0, 32'h0000_0FBF);
        pin_in = 12'h3FF; idle(5);
        pin_in = 12'h000; idle(5);
        pin_in = 12'h3FF; idle(5);
        cur_req = "R4";
        rd(4'd1, v); check("R4 trigger mix", v, 32'h0000_039F);
        check("R5 pin6 disabled", {31'h0, v[6]}, 32'h0);

        // R6: write-one clear, level re-set
        cur_req = "R6";
        wr(4'd3, 32'h0000_000E);
        rd(4'd1, v); check("R6 clear", v, 32'h0000_0399);
        wr(4'd3, 32'h0);
        rd(4'd1, v); check("R6 zero no effect", v, 32'h0000_0399);

        // R7 / R8: masking and display
        cur_req = "R7";
        wr(4'd4, 32'h0000_039F);
        check("R8 irq masked", {31'h0, irq}, 32'h0);
        rd(4'd2, v); check("R8 disp masked", v, 32'h0);
        wr(4'd5, 32'h0000_0008);
        cur_req = "R8";
        check("R8 irq unmasked", {31'h0, irq}, 32'h1);
        rd(4'd2, v); check("R8 disp", v, 32'h0000_0008);
        rd(4'd4, v); check("R7 mask readback", v, 32'h0000_0397);
        rd(4'd5, v); check("R7 mclr reads zero", v, 32'h0);

        // R9: status write ignored, no upper bits
        cur_req = "R9";
        wr(4'd1, 32'hFFFF_FFFF);
        rd(4'd1, v); check("R9 stat write ignored", v, 32'h0000_0399);
        pin_in = 12'hFFF; idle(5);
        rd(4'd1, v); check("R9 upper zero", v & 32'hFFFF_F000, 32'h0);

        // R10: registered read shows pre-write state
        cur_req = "R10";
        wr(4'd5, 32'h0000_0FFF);
        wr(4'd0, 32'h0);
        wr(4'd3, 32'h0000_0FFF);
        rd(4'd1, v); check("R10 status cleared", v, 32'h0);
        check("R10 irq low", {31'h0, irq}, 32'h0);
        wr(4'd0, 32'h0000_00AB);
        check("R10 old value", bus_rdata, 32'h0);
        rd(4'd0, v); check("R10 new value", v, 32'h0000_00AB);

        idle(2);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule